// File: doc/BRIEF.md
# Clock-Rate Divider Mode Controller

This block turns a free-running fast oscillator clock into a system-cycle enable. The enable runs at one of three speeds. In the multiplied-rate mode it is high on every oscillator cycle; the frequency multiplier itself is modelled and not built. In the unity-rate mode it is also high on every oscillator cycle. In the slow power-saving mode it is high for one cycle out of every 2^DIV_LOG2 oscillator cycles, which is 1024 with the defaults. The oscillator clock keeps running at full speed in every mode. Only the rate of the enable changes.

Software selects the speed by writing a 2-bit rate code through a single-cycle write port. Each write is checked against a transition rule. Any move into or out of the slow mode must start or end in the unity-rate mode. A write that breaks the rule, and a write of the reserved code, is dropped without any other effect. A hardware switchback input pulls the block out of the slow mode and back to unity rate. It does nothing in the other modes.

Top module: `clkrate_top`

## Requirements
- R1: A synchronous active-high reset puts the block in unity-rate mode (rate_mode = 10b) with the divide counter cleared, so sys_en reads 1 from the first cycle after reset.
- R2: The rate codes are 00b for the multiplied mode, 10b for unity rate and 11b for the slow mode. 01b is reserved.
- R3: In unity-rate mode (10b), sys_en is high on every oscillator cycle.
- R4: In multiplied mode (00b), sys_en is high on every oscillator cycle.
- R5: In slow mode (11b), sys_en is high for exactly one cycle in every 1024 cycles. The first pulse comes in the 1024th cycle after the mode was entered.
- R6: A write that asks for a direct move between 00b and 11b, in either direction, is ignored and rate_mode keeps its value.
- R7: A write of the reserved code 01b is ignored and rate_mode keeps its value.
- R8: When switchback is high while rate_mode is 11b, rate_mode becomes 10b at the next edge. This takes priority over a write in the same cycle.
- R9: When switchback is high while rate_mode is not 11b, it has no effect.
- R10: A write of the code that is already current is accepted but does not restart the divide counter, so the pulse spacing in slow mode is unchanged.
- R11: An accepted write shows on rate_mode at the clock edge that samples it. The new mode's enable pattern starts in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Rate write strobe, one cycle per write |
| wr_rate | input | 2 | Requested rate code |
| switchback | input | 1 | Hardware request to return from slow mode to unity rate |
| rate_mode | output | 2 | Current rate code |
| sys_en | output | 1 | System-cycle enable |

## Verification
A write or switchback sampled at a rising edge shows on rate_mode right after that edge. sys_en is decoded from registered state, so it changes in the same cycle as the new mode, and in slow mode it rises 1023 edges after entry. The bench drives every input on the falling edge and updates its own mode and count model once for each rising edge. It compares both outputs 1 ns after that edge, so each result is checked in the exact cycle it is due. Directed runs cover full slow-mode periods and each forbidden move. They are followed by long random stretches with sparse writes and switchback pulses.

// File: rtl/clkrate_pkg.sv
package clkrate_pkg;

    typedef enum logic [1:0] {
        RATE_X4   = 2'b00,
        RATE_RSVD = 2'b01,
        RATE_DIV1 = 2'b10,
        RATE_SLOW = 2'b11
    } rate_e;

    typedef struct packed {
        logic  valid;
        rate_e rate;
    } rate_req_t;

    // Legal when the target is not reserved and the move does not
    // jump straight between the multiplied and the slow mode.
    function automatic logic move_ok(rate_e cur, rate_e req);
        if (req == RATE_RSVD)                       return 1'b0;
        if (req == cur)                             return 1'b1;
        if (cur == RATE_DIV1 || req == RATE_DIV1)   return 1'b1;
        return 1'b0;
    endfunction

endpackage

// File: rtl/rate_ctrl.sv
module rate_ctrl
    import clkrate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rate_req_t req,
    input  logic      sb,
    output rate_e     mode_q,
    output logic      restart
);

    rate_e mode_d;

    always_comb begin
        mode_d = mode_q;
        if (sb && mode_q == RATE_SLOW)
            mode_d = RATE_DIV1;
        else if (req.valid && move_ok(mode_q, req.rate))
            mode_d = req.rate;
    end

    assign restart = (mode_d != mode_q);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= RATE_DIV1;
        else     mode_q <= mode_d;
    end

    assert_no_hop_up_R6: assert property (@(posedge clk) disable iff (rst)
        mode_q == RATE_X4 |=> mode_q != RATE_SLOW);

    assert_no_hop_down_R6: assert property (@(posedge clk) disable iff (rst)
        mode_q == RATE_SLOW |=> mode_q != RATE_X4);

    assert_rsvd_never_R7: assert property (@(posedge clk) disable iff (rst)
        mode_q != RATE_RSVD);

    assert_rsvd_dropped_R7: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.rate == RATE_RSVD && !sb) |=> $stable(mode_q));

    assert_switchback_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (sb && mode_q == RATE_SLOW) |=> mode_q == RATE_DIV1);

    assert_switchback_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (sb && mode_q != RATE_SLOW && !req.valid) |=> $stable(mode_q));

endmodule

// File: rtl/cycle_div.sv
module cycle_div
    import clkrate_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic  clk,
    input  logic  rst,
    input  rate_e mode,
    input  logic  restart,
    output logic  tick
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_q <= '0;
        else if (mode == RATE_SLOW)
            cnt_q <= cnt_q + 1'b1;
        else
            cnt_q <= '0;
    end

    always_comb begin
        tick = 1'b1;
        if (mode == RATE_SLOW)
            tick = (cnt_q == CNT_TOP);
    end

    assert_restart_clears_R5: assert property (@(posedge clk) disable iff (rst)
        restart |=> cnt_q == '0);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == RATE_SLOW && tick && !restart) |=> !tick);

    assert_fast_modes_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == RATE_DIV1 || mode == RATE_X4) |-> tick);

endmodule

// File: rtl/clkrate_top.sv
module clkrate_top
    import clkrate_pkg::*;
#(
    parameter int DIV_LOG2 = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_rate,
    input  logic       switchback,
    output logic [1:0] rate_mode,
    output logic       sys_en
);

    rate_req_t req;
    rate_e     mode_q;
    logic      restart;

    assign req.valid = wr_en;
    assign req.rate  = rate_e'(wr_rate);

    rate_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .sb      (switchback),
        .mode_q  (mode_q),
        .restart (restart)
    );

    cycle_div #(.CNT_W(DIV_LOG2)) u_div (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode_q),
        .restart (restart),
        .tick    (sys_en)
    );

    assign rate_mode = mode_q;

    assert_reset_mode_R1: assert property (@(posedge clk)
        $past(rst) |-> (rate_mode == 2'b10 && sys_en));

    assert_write_lands_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_rate == 2'b10 && !switchback) |=> rate_mode == 2'b10);

endmodule

// File: tb/test_clkrate_top.sv
`timescale 1ns/1ps
module test_clkrate_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_rate = 2'b10;
    logic       switchback = 1'b0;
    logic [1:0] rate_mode;
    logic       sys_en;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int em    = 2;   // expected mode code
    int ek    = 0;   // expected cycles since slow-mode entry, mod 1024

    always #2 clk = ~clk;

    clkrate_top i_clkrate_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_rate(wr_rate),
        .switchback(switchback), .rate_mode(rate_mode), .sys_en(sys_en)
    );

    function automatic bit legal(int cur, int req);
        if (req == 1) return 0;
        if (cur == 0 && req == 3) return 0;
        if (cur == 3 && req == 0) return 0;
        return 1;
    endfunction

    function automatic bit exp_en(int m, int k);
        return (m != 3) || (k == 1023);
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(bit we, logic [1:0] wr, bit sb, string tag);
        int nm;
        string etag;
        @(negedge clk);
        wr_en = we; wr_rate = wr; switchback = sb;
        nm = em;
        if (sb && em == 3) nm = 2;
        else if (we && legal(em, int'(wr))) nm = int'(wr);
        if (nm != em)     ek = 0;
        else if (em == 3) ek = (ek + 1) % 1024;
        else              ek = 0;
        em = nm;
        @(posedge clk); #1;
        etag = (em == 3) ? "R5" : (em == 0) ? "R4" : "R3";
        chk(int'(rate_mode) == em, tag, "rate_mode", int'(rate_mode), em);
        chk(sys_en == exp_en(em, ek), etag, "sys_en", int'(sys_en), int'(exp_en(em, ek)));
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 2'b10, 0, tag);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        chk(rate_mode == 2'b10, "R1", "reset rate_mode", int'(rate_mode), 2);
        chk(sys_en == 1'b1, "R1", "reset sys_en", int'(sys_en), 1);
        @(negedge clk); rst = 1'b0;
        em = 2; ek = 0;
        @(posedge clk); #1;
        chk(rate_mode == 2'b10 && sys_en, "R1", "after reset", int'(rate_mode), 2);
        idle(5, "R3");

        step(1, 2'b11, 0, "R11");          // enter slow mode
        idle(1100, "R5");
        step(1, 2'b00, 0, "R6");           // direct drop to 4X refused
        idle(20, "R6");
        step(1, 2'b01, 0, "R7");           // reserved code refused
        idle(300, "R2");
        step(1, 2'b11, 0, "R10");          // same code, no restart
        idle(1100, "R10");
        step(1, 2'b00, 1, "R8");           // switchback wins over write
        idle(3, "R8");
        step(0, 2'b10, 1, "R9");           // switchback in unity rate
        step(1, 2'b00, 0, "R4");           // into 4X
        idle(10, "R4");
        step(1, 2'b11, 0, "R6");           // direct rise to slow refused
        step(0, 2'b10, 1, "R9");           // switchback in 4X
        step(1, 2'b01, 0, "R7");
        step(1, 2'b10, 0, "R11");
        step(1, 2'b11, 0, "R2");
        idle(2050, "R5");
        step(0, 2'b10, 1, "R8");

        for (int i = 0; i < 40000; i++) begin
            bit we, sb;
            logic [1:0] wr;
            we = ($urandom % 400) == 0;
            sb = ($urandom % 700) == 0;
            wr = 2'($urandom);
            step(we, wr, sb, "R2");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule